// File: doc/BRIEF.md
# Single-Cycle Six-Operation Processor Core

This block is a 32-bit processor core that finishes one instruction on every rising clock edge. It fetches a word from its instruction store at the program counter and decodes it. It reads two source registers, computes a result and writes that result back, all before the next edge. Register reads, instruction reads and data reads are combinational. The program counter, the register bank and the data store all change on the same rising edge. The core handles six operations: register add, register subtract, OR with an unsigned immediate, word load, word store and branch-if-equal. It treats every other encoding as a no-op that only moves the program counter on by four.

Both word stores live inside the core. Each has a preload write port, so a bench or a boot agent can fill them while reset is held. A combinational debug port reads any register of the 32-entry bank. Reset clears only the program counter. Register and memory contents survive a reset.

Top module: `onecyc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and no register or data-store write from the core takes place. The first rising edge after `rst` falls executes the word at address 0.
- R2: Instruction fields: opcode is bits 31..26, first source bits 25..21, second source/target bits 20..16, register destination bits 15..11, function bits 5..0, immediate bits 15..0. Opcode 0x00 with function 0x21 writes src1 + src2 (modulo 2^32) to the register destination.
- R3: Opcode 0x00 with function 0x23 writes src1 − src2 (modulo 2^32) to the register destination.
- R4: Opcode 0x0D writes src1 OR the zero-extended immediate to the target register.
- R5: Opcode 0x23 loads into the target register the data word at byte address src1 + sign-extended immediate. The word index is byte-address bits [DAW+1:2].
- R6: Opcode 0x2B stores the target register to the data word at src1 + sign-extended immediate, and writes no register.
- R7: Opcode 0x04 writes no register. If src1 equals the target register, the next program counter is PC + 4 + (sign-extended immediate × 4). Otherwise it is PC + 4.
- R8: Every other encoding, including opcode 0x00 with a function other than 0x21 or 0x23, changes no register and no data word and advances the program counter by 4.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: A register written by one instruction is seen by the instruction on the next edge, and at the debug port right after the writing edge.
- R11: A preload write stores its data into the instruction or data store at the given word index on the rising edge.
- R12: The debug port returns the selected register's current contents combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| imem_ld_we | input | 1 | Instruction store preload write enable |
| imem_ld_addr | input | IAW | Instruction store preload word index |
| imem_ld_data | input | DW | Instruction store preload word |
| dmem_ld_we | input | 1 | Data store preload write enable (wins over a core store) |
| dmem_ld_addr | input | DAW | Data store preload word index |
| dmem_ld_data | input | DW | Data store preload word |
| dbg_reg_sel | input | 5 | Debug register select |
| dbg_reg_val | output | DW | Debug register contents |
| pc_out | output | DW | Current program counter |

## Verification
Each instruction retires on the rising edge that follows its fetch. After `rst` is released, the k-th rising edge has executed the k-th instruction on the taken path. Its register result and the new program counter are visible right after that edge. The bench drives all inputs on the falling edge, counts rising edges exactly, and samples `pc_out` and the debug port on the falling edge. A store can only be seen through a later load. Its effect is therefore checked one instruction later, through the register that the load fills.

// File: rtl/onecyc_pkg.sv
package onecyc_pkg;

    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] FN_ADD   = 6'h21;
    localparam logic [5:0] FN_SUB   = 6'h23;
    localparam logic [5:0] OPC_ORI  = 6'h0D;
    localparam logic [5:0] OPC_LOAD = 6'h23;
    localparam logic [5:0] OPC_STOR = 6'h2B;
    localparam logic [5:0] OPC_BEQ  = 6'h04;

    typedef enum logic [2:0] {
        K_NOP,
        K_ADD,
        K_SUB,
        K_ORI,
        K_LOAD,
        K_STORE,
        K_BEQ
    } op_kind_e;

    typedef enum logic [1:0] {
        FN_A_ADD,
        FN_A_SUB,
        FN_A_OR
    } alu_fn_e;

    typedef struct packed {
        logic    rf_we;
        logic    dst_rd;
        logic    use_imm;
        logic    imm_sext;
        alu_fn_e alu_fn;
        logic    wb_mem;
        logic    dm_we;
        logic    is_beq;
    } ctl_t;

endpackage

// File: rtl/onecyc_decode.sv
module onecyc_decode
    import onecyc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctl_t       ctl
);

    op_kind_e kind;

    always_comb begin
        kind = K_NOP;
        unique case (opcode)
            OPC_REG: begin
                if (funct == FN_ADD)      kind = K_ADD;
                else if (funct == FN_SUB) kind = K_SUB;
                else                      kind = K_NOP;
            end
            OPC_ORI:  kind = K_ORI;
            OPC_LOAD: kind = K_LOAD;
            OPC_STOR: kind = K_STORE;
            OPC_BEQ:  kind = K_BEQ;
            default:  kind = K_NOP;
        endcase
    end

    always_comb begin
        ctl = '{rf_we: 1'b0, dst_rd: 1'b0, use_imm: 1'b0, imm_sext: 1'b0,
                alu_fn: FN_A_ADD, wb_mem: 1'b0, dm_we: 1'b0, is_beq: 1'b0};
        unique case (kind)
            K_ADD: begin
                ctl.rf_we  = 1'b1;
                ctl.dst_rd = 1'b1;
                ctl.alu_fn = FN_A_ADD;
            end
            K_SUB: begin
                ctl.rf_we  = 1'b1;
                ctl.dst_rd = 1'b1;
                ctl.alu_fn = FN_A_SUB;
            end
            K_ORI: begin
                ctl.rf_we   = 1'b1;
                ctl.use_imm = 1'b1;
                ctl.alu_fn  = FN_A_OR;
            end
            K_LOAD: begin
                ctl.rf_we    = 1'b1;
                ctl.use_imm  = 1'b1;
                ctl.imm_sext = 1'b1;
                ctl.wb_mem   = 1'b1;
            end
            K_STORE: begin
                ctl.use_imm  = 1'b1;
                ctl.imm_sext = 1'b1;
                ctl.dm_we    = 1'b1;
            end
            K_BEQ: begin
                ctl.is_beq = 1'b1;
                ctl.alu_fn = FN_A_SUB;
            end
            K_NOP: begin
                ctl.rf_we = 1'b0;
            end
            default: begin
                ctl.rf_we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/onecyc_regbank.sv
module onecyc_regbank #(
    parameter int DW   = 32,
    parameter int NREG = 32,
    parameter int NRD  = 3,
    localparam int RAW = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [RAW-1:0]           waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [NRD-1:0][RAW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]   rdata
);

    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
    end

endmodule

// File: rtl/onecyc_alu.sv
module onecyc_alu
    import onecyc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_fn_e       fn,
    output logic [DW-1:0] y,
    output logic          same
);

    always_comb begin
        unique case (fn)
            FN_A_ADD: y = a + b;
            FN_A_SUB: y = a - b;
            FN_A_OR:  y = a | b;
            default:  y = '0;
        endcase
    end

    assign same = (a == b);

endmodule

// File: rtl/onecyc_wordmem.sv
module onecyc_wordmem #(
    parameter int DW = 32,
    parameter int AW = 6,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/onecyc_core.sv
module onecyc_core
    import onecyc_pkg::*;
#(
    parameter int DW   = 32,
    parameter int IAW  = 6,
    parameter int DAW  = 6,
    parameter int NREG = 32,
    localparam int RAW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           imem_ld_we,
    input  logic [IAW-1:0] imem_ld_addr,
    input  logic [DW-1:0]  imem_ld_data,
    input  logic           dmem_ld_we,
    input  logic [DAW-1:0] dmem_ld_addr,
    input  logic [DW-1:0]  dmem_ld_data,
    input  logic [RAW-1:0] dbg_reg_sel,
    output logic [DW-1:0]  dbg_reg_val,
    output logic [DW-1:0]  pc_out
);

    logic [DW-1:0]  pc_q, pc_nxt, pc_plus4, br_tgt;
    logic [DW-1:0]  instr;
    logic [5:0]     opc, fnc;
    logic [RAW-1:0] f_rs, f_rt, f_rd;
    logic [15:0]    imm16;
    logic [DW-1:0]  imm_s, imm_z, imm_ext;
    ctl_t           ctl;

    logic [2:0][RAW-1:0] rf_ra;
    logic [2:0][DW-1:0]  rf_rd;
    logic [DW-1:0]  rs_val, rt_val;
    logic           rf_we;
    logic [RAW-1:0] rf_waddr;
    logic [DW-1:0]  rf_wdata;

    logic [DW-1:0]  alu_b, alu_y;
    logic           alu_same, src_same;
    logic [DW-1:0]  dm_rdata;
    logic           dm_we_core;
    logic           dm_we;
    logic [DAW-1:0] dm_waddr;
    logic [DW-1:0]  dm_wdata;
    logic           unused_bits;

    // program counter register
    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_nxt;
    end

    assign pc_plus4 = pc_q + DW'(4);
    assign br_tgt   = pc_plus4 + {imm_s[DW-3:0], 2'b00};
    assign pc_nxt   = (ctl.is_beq && src_same) ? br_tgt : pc_plus4;
    assign pc_out   = pc_q;

    onecyc_wordmem #(.DW(DW), .AW(IAW)) u_imem (
        .clk   (clk),
        .we    (imem_ld_we),
        .waddr (imem_ld_addr),
        .wdata (imem_ld_data),
        .raddr (pc_q[IAW+1:2]),
        .rdata (instr)
    );

    assign opc   = instr[31:26];
    assign f_rs  = instr[25:21];
    assign f_rt  = instr[20:16];
    assign f_rd  = instr[15:11];
    assign fnc   = instr[5:0];
    assign imm16 = instr[15:0];
    assign imm_s = {{(DW-16){imm16[15]}}, imm16};
    assign imm_z = {{(DW-16){1'b0}}, imm16};

    onecyc_decode u_dec (
        .opcode (opc),
        .funct  (fnc),
        .ctl    (ctl)
    );

    assign rf_ra = {dbg_reg_sel, f_rt, f_rs};
    assign rs_val      = rf_rd[0];
    assign rt_val      = rf_rd[1];
    assign dbg_reg_val = rf_rd[2];

    assign rf_we    = ctl.rf_we & ~rst;
    assign rf_waddr = ctl.dst_rd ? f_rd : f_rt;
    assign rf_wdata = ctl.wb_mem ? dm_rdata : alu_y;

    onecyc_regbank #(.DW(DW), .NREG(NREG), .NRD(3)) u_rf (
        .clk   (clk),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (rf_ra),
        .rdata (rf_rd)
    );

    assign imm_ext = ctl.imm_sext ? imm_s : imm_z;
    assign alu_b   = ctl.use_imm ? imm_ext : rt_val;

    onecyc_alu #(.DW(DW)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .fn   (ctl.alu_fn),
        .y    (alu_y),
        .same (alu_same)
    );

    assign src_same = alu_same & ~ctl.use_imm;

    // preload port has priority over a core store
    assign dm_we_core = ctl.dm_we & ~rst;
    assign dm_we      = dmem_ld_we | dm_we_core;
    assign dm_waddr   = dmem_ld_we ? dmem_ld_addr : alu_y[DAW+1:2];
    assign dm_wdata   = dmem_ld_we ? dmem_ld_data : rt_val;

    onecyc_wordmem #(.DW(DW), .AW(DAW)) u_dmem (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (alu_y[DAW+1:2]),
        .rdata (dm_rdata)
    );

    assign unused_bits = ^{instr[10:6], pc_q[1:0], pc_q[DW-1:IAW+2],
                           alu_y[1:0], alu_y[DW-1:DAW+2]};

endmodule

// File: rtl/onecyc_core_chk.sv
module onecyc_core_chk #(
    parameter int DW  = 32,
    parameter int RAW = 5
) (
    input logic           clk,
    input logic           rst,
    input logic [DW-1:0]  pc_out,
    input logic [DW-1:0]  instr,
    input logic [DW-1:0]  rs_val,
    input logic [DW-1:0]  rt_val,
    input logic           rf_we,
    input logic           dm_we_core,
    input logic [RAW-1:0] dbg_reg_sel,
    input logic [DW-1:0]  dbg_reg_val
);

    logic [5:0]    c_op, c_fn;
    logic          c_known;
    logic [DW-1:0] c_off;

    assign c_op    = instr[31:26];
    assign c_fn    = instr[5:0];
    assign c_known = (c_op == 6'h0D) || (c_op == 6'h23) || (c_op == 6'h2B) ||
                     (c_op == 6'h04) ||
                     ((c_op == 6'h00) && ((c_fn == 6'h21) || (c_fn == 6'h23)));
    assign c_off   = {{(DW-18){instr[15]}}, instr[15:0], 2'b00};

    // R1
    pc_cleared_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> pc_out == '0);

    // R7
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (c_op != 6'h04 || rs_val != rt_val) |=> pc_out == $past(pc_out) + DW'(4));

    // R7
    branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (c_op == 6'h04 && rs_val == rt_val) |=> pc_out == $past(pc_out) + DW'(4) + $past(c_off));

    // R6
    no_rf_write_chk: assert property (@(posedge clk) disable iff (rst)
        (c_op == 6'h2B || c_op == 6'h04) |-> !rf_we);

    // R6
    store_only_chk: assert property (@(posedge clk) disable iff (rst)
        dm_we_core |-> c_op == 6'h2B);

    // R8
    nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !c_known |-> (!rf_we && !dm_we_core));

    // R9
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        dbg_reg_sel == '0 |-> dbg_reg_val == '0);

endmodule

bind onecyc_core onecyc_core_chk #(.DW(DW), .RAW(RAW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pc_out      (pc_out),
    .instr       (instr),
    .rs_val      (rs_val),
    .rt_val      (rt_val),
    .rf_we       (rf_we),
    .dm_we_core  (dm_we_core),
    .dbg_reg_sel (dbg_reg_sel),
    .dbg_reg_val (dbg_reg_val)
);

// File: tb/onecyc_core_tb.sv
`timescale 1ns/1ps
module onecyc_core_tb;

    localparam int DW  = 32;
    localparam int IAW = 6;
    localparam int DAW = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           imem_ld_we = 1'b0;
    logic [IAW-1:0] imem_ld_addr = '0;
    logic [DW-1:0]  imem_ld_data = '0;
    logic           dmem_ld_we = 1'b0;
    logic [DAW-1:0] dmem_ld_addr = '0;
    logic [DW-1:0]  dmem_ld_data = '0;
    logic [4:0]     dbg_reg_sel = '0;
    logic [DW-1:0]  dbg_reg_val;
    logic [DW-1:0]  pc_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    onecyc_core #(.DW(DW), .IAW(IAW), .DAW(DAW)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .imem_ld_we   (imem_ld_we),
        .imem_ld_addr (imem_ld_addr),
        .imem_ld_data (imem_ld_data),
        .dmem_ld_we   (dmem_ld_we),
        .dmem_ld_addr (dmem_ld_addr),
        .dmem_ld_data (dmem_ld_data),
        .dbg_reg_sel  (dbg_reg_sel),
        .dbg_reg_val  (dbg_reg_val),
        .pc_out       (pc_out)
    );

    function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                          input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic read_reg(input logic [4:0] r, output logic [31:0] v);
        dbg_reg_sel = r;
        #0.5;
        v = dbg_reg_val;
    endtask

    task automatic check_reg(input string tag, input logic [4:0] r, input logic [31:0] exp);
        logic [31:0] v;
        read_reg(r, v);
        check(tag, $sformatf("reg %0d", r), v, exp);
    endtask

    task automatic load_i(input int a, input logic [31:0] d);
        imem_ld_we = 1'b1; imem_ld_addr = IAW'(a); imem_ld_data = d;
        @(negedge clk);
        imem_ld_we = 1'b0;
    endtask

    task automatic load_d(input int a, input logic [31:0] d);
        dmem_ld_we = 1'b1; dmem_ld_addr = DAW'(a); dmem_ld_data = d;
        @(negedge clk);
        dmem_ld_we = 1'b0;
    endtask

    task automatic begin_prog();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < (1 << IAW); i++) load_i(i, 32'h0);
    endtask

    task automatic run(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    // arithmetic, immediate OR, register 0, no-ops, back-to-back use
    task automatic test_arith();
        begin_prog();
        load_i(0, enc_i(6'h0D, 0, 1, 16'h1234));
        load_i(1, enc_i(6'h0D, 0, 2, 16'hFFFF));
        load_i(2, enc_r(1, 2, 3, 6'h21));
        load_i(3, enc_r(1, 2, 4, 6'h23));
        load_i(4, enc_r(2, 2, 5, 6'h23));
        load_i(5, enc_r(1, 1, 0, 6'h21));
        load_i(6, enc_i(6'h0D, 1, 6, 16'h00F0));
        load_i(7, enc_r(3, 3, 7, 6'h21));
        load_i(8, 32'hFC00_0000);
        load_i(9, enc_r(2, 2, 1, 6'h20));
        run(3);
        check("R1", "pc held in reset", pc_out, 32'h0);
        rst = 1'b0;
        run(1);
        check("R1", "pc after first instruction", pc_out, 32'h4);
        check_reg("R10", 1, 32'h0000_1234);
        run(9);
        check("R8", "pc after no-ops", pc_out, 32'd40);
        check_reg("R4", 2, 32'h0000_FFFF);
        check_reg("R2", 3, 32'h0000_1234 + 32'h0000_FFFF);
        check_reg("R3", 4, 32'h0000_1234 - 32'h0000_FFFF);
        check_reg("R3", 5, 32'h0);
        check_reg("R9", 0, 32'h0);
        check_reg("R4", 6, 32'h0000_12F4);
        check_reg("R10", 7, 2 * (32'h0000_1234 + 32'h0000_FFFF));
        check_reg("R8", 1, 32'h0000_1234);
    endtask

    // preload, store, load with positive and negative offsets
    task automatic test_memory();
        begin_prog();
        load_d(0, 32'hCAFE_F00D);
        load_d(5, 32'h1111_1111);
        load_i(0, enc_i(6'h0D, 0, 1, 16'h0010));
        load_i(1, enc_i(6'h0D, 0, 2, 16'hBEEF));
        load_i(2, enc_i(6'h2B, 1, 2, 16'h0004));
        load_i(3, enc_i(6'h2B, 1, 1, 16'hFFF8));
        load_i(4, enc_i(6'h23, 1, 3, 16'h0004));
        load_i(5, enc_i(6'h23, 1, 4, 16'hFFF8));
        load_i(6, enc_i(6'h23, 0, 5, 16'h0000));
        load_i(7, enc_r(3, 4, 6, 6'h21));
        rst = 1'b0;
        run(8);
        check("R5", "pc after memory program", pc_out, 32'd32);
        check_reg("R11", 5, 32'hCAFE_F00D);
        check_reg("R6", 3, 32'h0000_BEEF);
        check_reg("R5", 4, 32'h0000_0010);
        check_reg("R6", 2, 32'h0000_BEEF);
        check_reg("R6", 1, 32'h0000_0010);
        check_reg("R10", 6, 32'h0000_BEEF + 32'h0000_0010);
    endtask

    // branches not taken, forward, backward and self-loop; mid-run reset
    task automatic test_branch();
        logic [31:0] r1_old, r4_old, r6_now;
        begin_prog();
        read_reg(1, r1_old);
        read_reg(4, r4_old);
        load_i(0, enc_i(6'h0D, 0, 1, 16'h0005));
        load_i(1, enc_i(6'h0D, 0, 2, 16'h0005));
        load_i(2, enc_i(6'h0D, 0, 3, 16'h0007));
        load_i(3, enc_i(6'h04, 1, 3, 16'h0005));
        load_i(4, enc_i(6'h04, 1, 2, 16'h0002));
        load_i(5, enc_i(6'h0D, 0, 4, 16'hAAAA));
        load_i(6, enc_i(6'h0D, 0, 4, 16'hBBBB));
        load_i(7, enc_i(6'h0D, 0, 5, 16'h0001));
        load_i(8, enc_i(6'h04, 0, 0, 16'h0003));
        load_i(9, enc_i(6'h0D, 0, 6, 16'h0066));
        load_i(10, enc_i(6'h04, 0, 0, 16'hFFFF));
        load_i(12, enc_r(5, 5, 5, 6'h21));
        load_i(13, enc_i(6'h04, 0, 0, 16'hFFFB));
        check_reg("R1", 1, r1_old);
        rst = 1'b0;
        run(4);
        check("R7", "pc after branch not taken", pc_out, 32'd16);
        run(1);
        check("R7", "pc after forward branch", pc_out, 32'd28);
        run(9);
        check("R7", "pc parked in self-loop", pc_out, 32'd40);
        check_reg("R7", 4, r4_old);
        check_reg("R7", 5, 32'h2);
        check_reg("R7", 6, 32'h66);
        read_reg(6, r6_now);
        rst = 1'b1;
        run(1);
        check("R1", "pc after mid-run reset", pc_out, 32'h0);
        check_reg("R1", 6, r6_now);
        rst = 1'b0;
        run(1);
        check("R12", "debug read after restart", pc_out, 32'h4);
        check_reg("R12", 1, 32'h5);
    endtask

    initial begin
        #(4.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        test_arith();
        test_memory();
        test_branch();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule